// File: doc/BRIEF.md
# Seven-Track Tape Character Codec

The codec sits between a 36-bit word channel and a seven-track tape data path. On the write side it takes one machine word and sends it out as six tape characters, one after another, starting with the most significant six bits. Each character carries six data bits and a parity bit. On the read side it collects six incoming 6-bit characters and puts them back together into one word, then raises a done strobe.

Two encodings are supported. In BCD mode the zero character is swapped for a substitute code, the zone bit is flipped on characters that have bit 4 set, and parity is even. In binary mode the data bits pass through unchanged and parity is odd. The mode comes from a single input that a neighbouring select decoder drives from bit 4 of its unit select field. A record that ends partway through a word is padded with zero characters.

Top module: `tape_char_codec`

## Requirements
- R1: After a synchronous active-low reset, `wr_ready` is 1, `tape_out_valid` is 0, `rd_done` is 0 and `rd_word` is 0.
- R2: Write characters leave in order: word bits 35..30 first, then each following six-bit group, and bits 5..0 last.
- R3: With `bin_mode` = 0 (BCD), a write character of 0 goes out as octal 12, a nonzero character with bit 4 set goes out with bit 5 inverted, and any other character goes out unchanged. The mode is sampled when the word is accepted.
- R4: `tape_out[6]` is the parity bit. In BCD mode it makes the count of ones in all seven bits even. In binary mode (`bin_mode` = 1) it makes that count odd, and bits 5..0 equal the word's bits unchanged.
- R5: One character transfers on each clock edge where `tape_out_valid` and `tape_out_ready` are both 1. While `tape_out_valid` is 1 and `tape_out_ready` is 0, the character stays valid and unchanged.
- R6: A word is accepted on an edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` then stays 0 until the sixth character has transferred. A word offered while `wr_ready` is 0 is not taken and produces no characters.
- R7: Read characters fill the word from bits 35..30 downward. In BCD mode an incoming octal 12 becomes 0, and a character with bit 4 set has bit 5 inverted. In binary mode characters are used unchanged.
- R8: `rd_done` is 1 for exactly the one cycle after the edge that accepts the sixth character, and `rd_word` carries the word in that cycle. `rd_word` holds its value until the next completion.
- R9: If `tape_in_last` is 1 with a character before the sixth, the word completes at once with all later character positions zero. Done timing is as in R8, and the next character starts a new word at bits 35..30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bin_mode | input | 1 | 0 = BCD encoding, 1 = binary encoding |
| wr_word | input | 36 | Word to be written |
| wr_valid | input | 1 | `wr_word` is offered |
| wr_ready | output | 1 | Codec can accept a word |
| tape_out | output | 7 | Outgoing character, parity in bit 6 |
| tape_out_valid | output | 1 | `tape_out` holds a character |
| tape_out_ready | input | 1 | Sink takes the character |
| tape_in | input | 6 | Data bits of the incoming tape character |
| tape_in_valid | input | 1 | `tape_in` holds a character |
| tape_in_last | input | 1 | This character ends the record |
| rd_word | output | 36 | Assembled word |
| rd_done | output | 1 | One-cycle pulse: `rd_word` is new |

## Verification
The first write character shows on `tape_out` in the cycle right after the accepting edge. Each later one shows in the cycle after the edge that took the one before, so the scoreboard pops an expected character only at the half-cycle point just before an edge where valid and ready are both high. The assembled word appears with `rd_done` in the cycle after the edge that takes the sixth character or the marked last one. The bench therefore checks `rd_done` high at the next falling edge and low one cycle later, with `rd_word` still held. Stimulus changes two nanoseconds after a rising edge and every sample is taken on the falling edge, so no check depends on the order of processes at an edge.

// File: rtl/tape_codec_pkg.sv
// Shared constants and types for the seven-track tape character codec.
package tape_codec_pkg;
    // Data bits per tape character; the encoding rules refer to bits 4 and 5.
    localparam int CHAR_W        = 6;
    // Character width on tape: data bits plus one parity bit on top.
    localparam int TAPE_W        = CHAR_W + 1;
    // Substitute code used for a zero character in BCD mode.
    localparam logic [CHAR_W-1:0] BCD_ZERO_CODE = 6'o12;
    // Data bit that, when set, flips the zone bit in BCD mode.
    localparam int ZONE_TRIG_BIT = 4;
    // Zone bit that gets flipped.
    localparam int ZONE_BIT      = 5;

    typedef enum logic {
        ENC_BCD = 1'b0,
        ENC_BIN = 1'b1
    } enc_mode_e;
endpackage

// File: rtl/tape_char_encode.sv
// Encodes one 6-bit character into a 7-bit tape character.
// Assumes: purely combinational; the caller holds data and mode stable.
module tape_char_encode
    import tape_codec_pkg::*;
(
    input  logic [CHAR_W-1:0] data_i,
    input  enc_mode_e         mode_i,
    output logic [TAPE_W-1:0] tape_o
);
    logic [CHAR_W-1:0] mapped;
    logic              par;

    // Apply the BCD substitutions and build the parity bit.
    always_comb begin
        mapped = data_i;
        if (mode_i == ENC_BCD) begin
            if (data_i == '0) begin
                mapped = BCD_ZERO_CODE;
            end else if (data_i[ZONE_TRIG_BIT]) begin
                mapped[ZONE_BIT] = ~data_i[ZONE_BIT];
            end
        end
        // Even total for BCD, odd total for binary.
        par    = (mode_i == ENC_BCD) ? (^mapped) : ~(^mapped);
        tape_o = {par, mapped};
    end
endmodule

// File: rtl/tape_char_decode.sv
// Decodes the data bits of one tape character back into a 6-bit character.
// Assumes: purely combinational; parity is not checked here.
module tape_char_decode
    import tape_codec_pkg::*;
(
    input  logic [CHAR_W-1:0] raw_i,
    input  enc_mode_e         mode_i,
    output logic [CHAR_W-1:0] data_o
);
    // Undo the BCD substitutions; binary passes through.
    always_comb begin
        data_o = raw_i;
        if (mode_i == ENC_BCD) begin
            if (raw_i == BCD_ZERO_CODE) begin
                data_o = '0;
            end else if (raw_i[ZONE_TRIG_BIT]) begin
                data_o[ZONE_BIT] = ~raw_i[ZONE_BIT];
            end
        end
    end
endmodule

// File: rtl/tape_wr_serializer.sv
// Write path: accepts a word and sends it out as CHARS encoded characters,
// most significant group first, one per transfer on a valid/ready link.
// Assumes: a new word is taken only when the previous one has fully left;
// the encoding mode is captured together with the word.
module tape_wr_serializer
    import tape_codec_pkg::*;
#(
    parameter int CHARS = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CHAR_W*CHARS-1:0]   word_i,
    input  logic                      word_valid_i,
    output logic                      word_ready_o,
    input  enc_mode_e                 mode_i,
    output logic [TAPE_W-1:0]         char_o,
    output logic                      char_valid_o,
    input  logic                      char_ready_i
);
    localparam int WORD_W = CHAR_W * CHARS;
    localparam int CNT_W  = (CHARS > 1) ? $clog2(CHARS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHARS - 1);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              busy;
    enc_mode_e         mode_q;

    // Load a word when idle, then shift one character out per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            cnt    <= '0;
            busy   <= 1'b0;
            mode_q <= ENC_BCD;
        end else if (!busy) begin
            if (word_valid_i) begin
                shreg  <= word_i;
                cnt    <= '0;
                busy   <= 1'b1;
                mode_q <= mode_i;
            end
        end else if (char_ready_i) begin
            shreg <= shreg << CHAR_W;
            if (cnt == LAST_IDX) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign word_ready_o = !busy;
    assign char_valid_o = busy;

    tape_char_encode u_enc (
        .data_i (shreg[WORD_W-1 -: CHAR_W]),
        .mode_i (mode_q),
        .tape_o (char_o)
    );
endmodule

// File: rtl/tape_rd_assembler.sv
// Read path: collects decoded characters into a word, top group first.
// A record end before the last group pads the remaining groups with zero.
// Assumes: mode is stable over the characters of one word.
module tape_rd_assembler
    import tape_codec_pkg::*;
#(
    parameter int CHARS = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CHAR_W-1:0]         char_i,
    input  logic                      char_valid_i,
    input  logic                      rec_end_i,
    input  enc_mode_e                 mode_i,
    output logic [CHAR_W*CHARS-1:0]   word_o,
    output logic                      done_o
);
    localparam int WORD_W = CHAR_W * CHARS;
    localparam int ACC_W  = WORD_W - CHAR_W;
    localparam int CNT_W  = (CHARS > 1) ? $clog2(CHARS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHARS - 1);

    logic [ACC_W-1:0]  acc;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] word_q;
    logic              done_q;
    logic [CHAR_W-1:0] dec;
    logic [WORD_W-1:0] acc_next;
    logic [WORD_W-1:0] aligned;
    logic              finish;

    tape_char_decode u_dec (
        .raw_i  (char_i),
        .mode_i (mode_i),
        .data_o (dec)
    );

    // Append the new character and left-align a short word.
    always_comb begin
        acc_next = {acc, dec};
        finish   = char_valid_i && (rec_end_i || (cnt == LAST_IDX));
        aligned  = acc_next;
        for (int k = 0; k < CHARS; k++) begin
            if (cnt == CNT_W'(k)) begin
                aligned = acc_next << (CHAR_W * (CHARS - 1 - k));
            end
        end
    end

    // Track the fill count and publish a finished word with a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            cnt    <= '0;
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (finish) begin
                word_q <= aligned;
                done_q <= 1'b1;
                acc    <= '0;
                cnt    <= '0;
            end else if (char_valid_i) begin
                acc <= acc_next[ACC_W-1:0];
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign word_o = word_q;
    assign done_o = done_q;
endmodule

// File: rtl/tape_char_codec.sv
// Top: seven-track tape character codec, write serializer plus read assembler.
// Assumes: bin_mode is driven from the select field's bit 4 by a neighbour;
// the two paths run independently and share only the mode input.
module tape_char_codec
    import tape_codec_pkg::*;
#(
    parameter int CHARS  = 6,
    parameter int WORD_W = CHAR_W * CHARS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bin_mode,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [TAPE_W-1:0] tape_out,
    output logic              tape_out_valid,
    input  logic              tape_out_ready,
    input  logic [CHAR_W-1:0] tape_in,
    input  logic              tape_in_valid,
    input  logic              tape_in_last,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_done
);
    enc_mode_e mode;

    // Map the mode pin onto the encoding type.
    always_comb mode = enc_mode_e'(bin_mode);

    tape_wr_serializer #(.CHARS(CHARS)) u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_i       (wr_word),
        .word_valid_i (wr_valid),
        .word_ready_o (wr_ready),
        .mode_i       (mode),
        .char_o       (tape_out),
        .char_valid_o (tape_out_valid),
        .char_ready_i (tape_out_ready)
    );

    tape_rd_assembler #(.CHARS(CHARS)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .char_i       (tape_in),
        .char_valid_i (tape_in_valid),
        .rec_end_i    (tape_in_last),
        .mode_i       (mode),
        .word_o       (rd_word),
        .done_o       (rd_done)
    );
endmodule

// File: rtl/tape_codec_chk.sv
// Checker for the tape character codec, attached by bind below.
// Assumes: observes top-level ports only; tracks the latched mode itself.
module tape_codec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bin_mode,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [6:0]  out_char,
    input logic        out_valid,
    input logic        out_ready,
    input logic        in_valid,
    input logic [35:0] rd_word,
    input logic        rd_done
);
    logic mode_seen;

    // Remember the mode in force when the current word was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_seen <= 1'b0;
        else if (wr_valid && wr_ready) mode_seen <= bin_mode;
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_char)));

    // R6
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !wr_ready);

    // R6
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> out_valid);

    // R4
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((^out_char) == mode_seen));

    // R3
    bcd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mode_seen) |-> (out_char[5:0] != 6'o00));

    // R8
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(in_valid));

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |-> $stable(rd_word));
endmodule

bind tape_char_codec tape_codec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bin_mode  (bin_mode),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .out_char  (tape_out),
    .out_valid (tape_out_valid),
    .out_ready (tape_out_ready),
    .in_valid  (tape_in_valid),
    .rd_word   (rd_word),
    .rd_done   (rd_done)
);

// File: tb/tb_tape_char_codec.sv
module tb_tape_char_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bin_mode = 1'b0;
    logic [35:0] wr_word = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [6:0]  tape_out;
    logic        tape_out_valid;
    logic        tape_out_ready = 1'b1;
    logic [5:0]  tape_in = '0;
    logic        tape_in_valid = 1'b0;
    logic        tape_in_last = 1'b0;
    logic [35:0] rd_word;
    logic        rd_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int rdy_mode = 0;

    logic [6:0]  exp_chars[$];
    logic [35:0] exp_words[$];

    always #4 clk = ~clk;

    tape_char_codec dut (
        .clk(clk), .rst_n(rst_n), .bin_mode(bin_mode),
        .wr_word(wr_word), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .tape_out(tape_out), .tape_out_valid(tape_out_valid),
        .tape_out_ready(tape_out_ready),
        .tape_in(tape_in), .tape_in_valid(tape_in_valid),
        .tape_in_last(tape_in_last),
        .rd_word(rd_word), .rd_done(rd_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
        end
    endtask

    // Reference encoding written from R3/R4.
    function automatic logic [6:0] enc_ref(input logic [5:0] c, input bit bin);
        logic [5:0] m = c;
        logic p;
        if (!bin) begin
            if (c == 6'o00) m = 6'o12;
            else if (c[4]) m = {~c[5], c[4:0]};
        end
        if (bin) p = ($countones(m) % 2 == 0);
        else     p = ($countones(m) % 2 == 1);
        return {p, m};
    endfunction

    // Reference decoding written from R7.
    function automatic logic [5:0] dec_ref(input logic [5:0] c, input bit bin);
        if (bin) return c;
        if (c == 6'o12) return 6'o00;
        if (c[4]) return {~c[5], c[4:0]};
        return c;
    endfunction

    // Sink ready pattern.
    initial begin
        int ph = 0;
        logic [7:0] pat = 8'b1011_0010;
        forever begin
            @(posedge clk); #2;
            tape_out_ready = (rdy_mode == 0) ? 1'b1 : pat[ph % 8];
            ph++;
        end
    end

    // Monitor: write characters (R2 R3 R4) and stall hold (R5).
    initial begin
        bit         prev_stall = 1'b0;
        logic [6:0] prev_char = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_stall)
                    check(tape_out_valid && tape_out == prev_char, "R5",
                          "stalled char held", {56'd0, tape_out}, {56'd0, prev_char});
                if (tape_out_valid && tape_out_ready) begin
                    if (exp_chars.size() == 0) begin
                        check(1'b0, "R6", "unexpected char", {56'd0, tape_out}, 64'd0);
                    end else begin
                        logic [6:0] e;
                        e = exp_chars.pop_front();
                        check(tape_out == e, "R2 R3 R4", "write char",
                              {56'd0, tape_out}, {56'd0, e});
                    end
                end
                prev_stall = tape_out_valid && !tape_out_ready;
                prev_char  = tape_out;
            end
        end
    end

    // Monitor: assembled words (R7 R9).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_done) begin
                if (exp_words.size() == 0) begin
                    check(1'b0, "R8", "unexpected done", {28'd0, rd_word}, 64'd0);
                end else begin
                    logic [35:0] e;
                    e = exp_words.pop_front();
                    check(rd_word == e, "R7 R9", "read word",
                          {28'd0, rd_word}, {28'd0, e});
                end
            end
        end
    end

    // Driver: one write word; optionally offer another word while busy (R6).
    task automatic send_word(input logic [35:0] w, input bit bin, input bit poke);
        @(posedge clk); #2;
        while (!wr_ready) begin @(posedge clk); #2; end
        bin_mode = bin;
        wr_word  = w;
        wr_valid = 1'b1;
        for (int k = 0; k < 6; k++) exp_chars.push_back(enc_ref(w[35-6*k -: 6], bin));
        @(posedge clk); #2;
        if (poke) begin
            wr_word  = ~w;
            bin_mode = ~bin;
        end else begin
            wr_valid = 1'b0;
        end
        @(negedge clk);
        check(!wr_ready && tape_out_valid, "R6", "busy after accept",
              {62'd0, wr_ready, tape_out_valid}, 64'd1);
        if (poke) begin
            repeat (2) begin @(posedge clk); #2; end
            wr_valid = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_chars.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    // Driver: n read characters, the last marked when n < 6 (R9).
    task automatic send_rd(input logic [5:0] cs[6], input int n, input bit bin);
        logic [35:0] w = '0;
        for (int i = 0; i < n; i++) w[35-6*i -: 6] = dec_ref(cs[i], bin);
        exp_words.push_back(w);
        @(posedge clk); #2;
        bin_mode = bin;
        for (int i = 0; i < n; i++) begin
            tape_in       = cs[i];
            tape_in_valid = 1'b1;
            tape_in_last  = (n < 6) && (i == n - 1);
            @(posedge clk); #2;
        end
        tape_in_valid = 1'b0;
        tape_in_last  = 1'b0;
        @(negedge clk);
        check(rd_done == 1'b1, "R8", "done one cycle after last char",
              {63'd0, rd_done}, 64'd1);
        @(negedge clk);
        check(rd_done == 1'b0, "R8", "done is one cycle", {63'd0, rd_done}, 64'd0);
        check(rd_word == w, "R8", "word held", {28'd0, rd_word}, {28'd0, w});
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] cs[6];
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(wr_ready == 1'b1, "R1", "wr_ready", {63'd0, wr_ready}, 64'd1);
        check(tape_out_valid == 1'b0, "R1", "tape_out_valid", {63'd0, tape_out_valid}, 64'd0);
        check(rd_done == 1'b0, "R1", "rd_done", {63'd0, rd_done}, 64'd0);
        check(rd_word == '0, "R1", "rd_word", {28'd0, rd_word}, 64'd0);

        // R3: zero word in BCD gives the substitute code.
        send_word(36'o000000000000, 1'b0, 1'b0); drain();
        // R3: zone inversion and plain characters.
        send_word(36'o210177401205, 1'b0, 1'b0); drain();
        // R4: binary passes through with odd parity.
        send_word(36'o000000000000, 1'b1, 1'b0); drain();
        send_word(36'o123456701234, 1'b1, 1'b0); drain();
        // R5: backpressure pattern.
        rdy_mode = 1;
        send_word(36'o765432107654, 1'b1, 1'b0); drain();
        send_word(36'o303132333435, 1'b0, 1'b0); drain();
        // R6: offer another word while busy, also flipping mode; must be ignored.
        send_word(36'o111122223333, 1'b0, 1'b1); drain();
        rdy_mode = 0;
        // R2: back-to-back words.
        send_word(36'o700000000007, 1'b1, 1'b0);
        send_word(36'o060504030201, 1'b0, 1'b0); drain();

        // R7: BCD read with substitute code and zone inversion.
        cs = '{6'o12, 6'o61, 6'o01, 6'o20, 6'o00, 6'o77};
        send_rd(cs, 6, 1'b0);
        // R7: binary read unchanged.
        cs = '{6'o12, 6'o61, 6'o01, 6'o20, 6'o00, 6'o77};
        send_rd(cs, 6, 1'b1);
        // R9: short records padded with zero.
        cs = '{6'o45, 6'o12, 6'o33, 6'o00, 6'o00, 6'o00};
        send_rd(cs, 3, 1'b0);
        cs = '{6'o77, 6'o00, 6'o00, 6'o00, 6'o00, 6'o00};
        send_rd(cs, 1, 1'b1);
        // R9: next word starts at the top group again.
        cs = '{6'o01, 6'o02, 6'o03, 6'o04, 6'o05, 6'o06};
        send_rd(cs, 6, 1'b1);

        repeat (4) @(posedge clk);
        check(exp_chars.size() == 0, "R6", "all chars emitted", exp_chars.size(), 64'd0);
        check(exp_words.size() == 0, "R8", "all words done", exp_words.size(), 64'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule